// File: doc/BRIEF.md
# Compare/Capture Timer

A 16-bit up-counter that advances once for every system-clock cycle on which a count-enable input is high. Software controls it through a small write port. The port holds a control register, two pure compare registers and two dual-role registers. Each dual-role register is either a compare value or a capture holder, depending on its mode bit. A mode bit picks between two ways of counting. In interval mode the counter reloads to zero one count step after it meets compare register 0. In free-running mode it covers the whole 16-bit range and sets a sticky wrap flag.

Each channel drives its own one-cycle interrupt pulse. A compare channel pulses when the counter equals its register during a count step. A capture channel does three things when its external trigger input shows the selected edge: it passes the trigger through a two-flop synchronizer, latches the counter, and pulses its interrupt.

Top module: `cc_timer`

## Requirements
- R1: After an active-low reset, the counter, the wrap flag, all interrupt outputs, all compare/capture registers and the control register are zero.
- R2: While the run bit (control bit 0) is 1, the counter increases by one on each clock where `cntEn` is high and holds otherwise. While the run bit is 0, the counter is held at zero.
- R3: In interval mode (control bit 1 = 1), a count step taken while the counter equals compare register 0 (address 1) loads zero instead of incrementing. The period is therefore that value plus one count steps.
- R4: In free-running mode (control bit 1 = 0), the counter wraps from 0xFFFF to 0x0000. The wrap flag is set on the count step that moves the counter to 0xFFFF.
- R5: The wrap flag stays set until a write to address 5 with data bit 0 = 1. If a set and such a write fall on the same clock, the flag stays set.
- R6: For compare registers at addresses 1 and 2, `cmIrq[i]` is high for exactly the one clock after a count step taken while the counter equals that register.
- R7: A dual-role register (addresses 3 and 4) whose capture bit (control bit 2 for channel 0, bit 3 for channel 1) is 0 acts as a compare register. It raises `ccIrq[i]` in the same way as R6.
- R8: With its capture bit set, a channel's trigger is synchronized through two flops. The edge select is control bits [5:4] for channel 0 and [7:6] for channel 1: 00 = off, 01 = rising, 10 = falling, 11 = both. On a selected edge the channel copies the counter into its register and pulses `ccIrq[i]`, both visible three clock edges after the trigger input changes. When a capture and a software write to that register fall on the same clock, the capture wins.
- R9: A channel in capture mode raises no match interrupt, and edges that the select does not enable cause neither a capture nor an interrupt.
- R10: Every register write takes effect on the clock that samples it, so a new compare value is used for the very next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count-clock enable, one count step per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 control, 1-2 compare, 3-4 dual-role, 5 flag clear |
| wrData | input | 16 | Write data |
| capIn | input | 2 | Asynchronous capture trigger inputs, one per dual-role channel |
| count | output | 16 | Current counter value |
| ovfFlag | output | 1 | Sticky wrap flag |
| cmIrq | output | 2 | Compare-channel interrupt pulses |
| ccIrq | output | 2 | Dual-role channel interrupt pulses |
| ccVal0 | output | 16 | Contents of dual-role register 0 |
| ccVal1 | output | 16 | Contents of dual-role register 1 |

## Verification
The counter, the wrap flag, the compare pulses and register writes each change on the first rising edge after their inputs are sampled. A capture, together with its interrupt, appears on the third rising edge after the trigger pin moves, because of the synchronizer and the edge-detect flop. The bench drives inputs on falling edges. At every posedge it steps a behavioural model with the same latencies, and it compares all outputs on the next falling edge, so each result is checked in the exact cycle it is due. Directed checks cover three cases: a capture colliding with a software write, a flag clear on the wrap step, and stopping the run bit.

// File: rtl/cctmr_pkg.sv
package cctmr_pkg;
  localparam int NCM = 2;                     // pure compare channels
  localparam int NCC = 2;                     // dual-role channels
  localparam int NWR = NCM + NCC;             // writable value registers
  localparam int RUN_BIT = 0;
  localparam int INTV_BIT = 1;
  localparam int CAPM_LSB = 2;                // one capture-mode bit per channel
  localparam int EDGE_LSB = CAPM_LSB + NCC;   // two edge-select bits per channel
  localparam int CTRL_W = EDGE_LSB + 2 * NCC;
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_VAL0 = 3'd1;    // first of NWR value addresses
  localparam logic [2:0] ADDR_CLR = 3'd5;

  typedef struct packed {
    logic step;              // counter advances this cycle
    logic zero;              // counter loads zero this cycle
    logic [NCC-1:0] capMode; // channel is in capture role
    logic [NCC-1:0] capLoad; // channel captures this cycle
    logic [NWR-1:0] wrSel;   // value register write enables
  } tmrStrb_t;
endpackage

// File: rtl/cctmr_ctrl.sv
module cctmr_ctrl
  import cctmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CTRL_W-1:0] cfgData,
  input  logic [NCC-1:0]    capIn,
  input  logic [W-1:0]      count,
  input  logic              hitPeriod,
  output tmrStrb_t          strb,
  output logic              ovfFlag
);
  localparam logic [W-1:0] PRE_MAX = {{(W-1){1'b1}}, 1'b0};

  logic [CTRL_W-1:0] ctrlReg;
  logic [NCC-1:0] syncA, syncB, syncC, edgeHit;
  logic [NWR-1:0] wrSel;
  logic run, interval, step, ovfSet, ovfClr;

  assign run      = ctrlReg[RUN_BIT];
  assign interval = ctrlReg[INTV_BIT];
  assign step     = run && cntEn;
  assign ovfSet   = step && !interval && (count == PRE_MAX);
  assign ovfClr   = wrEn && (wrAddr == ADDR_CLR) && cfgData[0];

  for (genvar ch = 0; ch < NCC; ch++) begin : g_edge
    logic [1:0] sel;
    assign sel = ctrlReg[EDGE_LSB + 2*ch +: 2];
    assign edgeHit[ch] = (sel[0] & syncB[ch] & ~syncC[ch]) |
                         (sel[1] & ~syncB[ch] & syncC[ch]);
  end

  for (genvar k = 0; k < NWR; k++) begin : g_wsel
    assign wrSel[k] = wrEn && (wrAddr == ADDR_VAL0 + 3'(k));
  end

  always_comb begin
    strb.step    = step;
    strb.zero    = !run || (step && interval && hitPeriod);
    strb.capMode = ctrlReg[CAPM_LSB +: NCC];
    strb.capLoad = ctrlReg[CAPM_LSB +: NCC] & edgeHit;
    strb.wrSel   = wrSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      syncA   <= '0;
      syncB   <= '0;
      syncC   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (wrEn && wrAddr == ADDR_CTRL) ctrlReg <= cfgData;
      syncA <= capIn;
      syncB <= syncA;
      syncC <= syncB;
      if (ovfSet)      ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/cctmr_dp.sv
module cctmr_dp
  import cctmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  tmrStrb_t       strb,
  input  logic [W-1:0]   wrData,
  output logic [W-1:0]   count,
  output logic           hitPeriod,
  output logic [NCM-1:0] cmIrq,
  output logic [NCC-1:0] ccIrq,
  output logic [W-1:0]   ccVal [NCC]
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cmReg [NCM];
  logic [W-1:0] ccReg [NCC];
  logic [NCM-1:0] cmHit;
  logic [NCC-1:0] ccHit;

  always_comb begin
    for (int i = 0; i < NCM; i++) cmHit[i] = (count == cmReg[i]);
    for (int i = 0; i < NCC; i++) ccHit[i] = (count == ccReg[i]);
  end

  assign hitPeriod = cmHit[0];
  assign ccVal = ccReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      cmIrq <= '0;
      ccIrq <= '0;
      for (int i = 0; i < NCM; i++) cmReg[i] <= '0;
      for (int i = 0; i < NCC; i++) ccReg[i] <= '0;
    end else begin
      if (strb.zero)      count <= '0;
      else if (strb.step) count <= count + ONE;
      cmIrq <= cmHit & {NCM{strb.step}};
      ccIrq <= strb.capLoad | (~strb.capMode & ccHit & {NCC{strb.step}});
      for (int i = 0; i < NCM; i++)
        if (strb.wrSel[i]) cmReg[i] <= wrData;
      for (int i = 0; i < NCC; i++) begin
        if (strb.capLoad[i])          ccReg[i] <= count;
        else if (strb.wrSel[NCM + i]) ccReg[i] <= wrData;
      end
    end
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cctmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cntEn,
  input  logic           wrEn,
  input  logic [2:0]     wrAddr,
  input  logic [W-1:0]   wrData,
  input  logic [NCC-1:0] capIn,
  output logic [W-1:0]   count,
  output logic           ovfFlag,
  output logic [NCM-1:0] cmIrq,
  output logic [NCC-1:0] ccIrq,
  output logic [W-1:0]   ccVal0,
  output logic [W-1:0]   ccVal1
);
  tmrStrb_t strb;
  logic hitPeriod;
  logic [W-1:0] ccVal [NCC];

  cctmr_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .cfgData(wrData[CTRL_W-1:0]), .capIn(capIn), .count(count),
    .hitPeriod(hitPeriod), .strb(strb), .ovfFlag(ovfFlag)
  );

  cctmr_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .count(count),
    .hitPeriod(hitPeriod), .cmIrq(cmIrq), .ccIrq(ccIrq), .ccVal(ccVal)
  );

  assign ccVal0 = ccVal[0];
  assign ccVal1 = ccVal[1];
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cctmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic           cntEn,
  input logic           wrEn,
  input logic [2:0]     wrAddr,
  input logic           clrBit,
  input logic [W-1:0]   count,
  input logic           ovfFlag,
  input logic [NCM-1:0] cmIrq,
  input logic [NCC-1:0] ccIrq,
  input tmrStrb_t       strb,
  input logic           hitPeriod
);
  // R2: without an enable the counter only holds or is forced to zero
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> (count == $past(count)) || (count == '0));

  // R2: the counter never moves by more than one step
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + W'(1)) || (count == '0));

  // R3, R6: a step on the period match reloads zero and pulses channel 0
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && hitPeriod && strb.zero |=> (count == '0) && cmIrq[0]);

  // R4: the flag rises only as the counter reaches all ones
  p_ovf_at_max_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (count == '1));

  // R5: only a clear write can drop the flag
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !(wrEn && wrAddr == ADDR_CLR && clrBit) |=> ovfFlag);

  // R9: a capture-role channel is silent unless it captures
  p_capquiet0_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.capMode[0] && !strb.capLoad[0] |=> !ccIrq[0]);
  p_capquiet1_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.capMode[1] && !strb.capLoad[1] |=> !ccIrq[1]);
endmodule

bind cc_timer cc_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .clrBit(wrData[0]), .count(count), .ovfFlag(ovfFlag), .cmIrq(cmIrq),
  .ccIrq(ccIrq), .strb(strb), .hitPeriod(hitPeriod)
);

// File: tb/cc_timer_tb.sv
`timescale 1ns/1ps
module cc_timer_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, cntEn, wrEn;
  logic [2:0] wrAddr;
  logic [15:0] wrData;
  logic [1:0] capIn;
  logic [15:0] count, ccVal0, ccVal1;
  logic ovfFlag;
  logic [1:0] cmIrq, ccIrq;

  cc_timer #(.W(16)) u_dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .capIn(capIn), .count(count), .ovfFlag(ovfFlag),
    .cmIrq(cmIrq), .ccIrq(ccIrq), .ccVal0(ccVal0), .ccVal1(ccVal1)
  );

  int nChk = 0, nBad = 0;
  bit cmpOn = 1'b0, done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped on each rising edge
  logic [15:0] mCount, mCm[2], mCc[2];
  logic [7:0] mCtrl;
  logic mOvf;
  logic [1:0] mCmIrq, mCcIrq, mS1, mS2, mS3;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount = 0; mCtrl = 0; mOvf = 0; mCmIrq = 0; mCcIrq = 0;
      mS1 = 0; mS2 = 0; mS3 = 0;
      for (int i = 0; i < 2; i++) begin mCm[i] = 0; mCc[i] = 0; end
    end else begin
      bit run, intv, stp, clr;
      logic [1:0] ld, nCm, nCc;
      logic [15:0] oldCount;
      run = mCtrl[0]; intv = mCtrl[1]; stp = run && cntEn;
      oldCount = mCount;
      for (int i = 0; i < 2; i++) begin
        bit rise, fall;
        logic [1:0] sel;
        sel = mCtrl[4 + 2*i +: 2];
        rise = mS2[i] && !mS3[i];
        fall = !mS2[i] && mS3[i];
        ld[i] = mCtrl[2+i] && ((sel == 2'b01 && rise) || (sel == 2'b10 && fall) || (sel == 2'b11 && (rise || fall)));
        nCm[i] = stp && (oldCount == mCm[i]);
        nCc[i] = mCtrl[2+i] ? ld[i] : (stp && oldCount == mCc[i]);
      end
      clr = wrEn && wrAddr == 3'd5 && wrData[0];
      if (stp && !intv && oldCount == 16'hFFFE) mOvf = 1;
      else if (clr) mOvf = 0;
      if (!run || (stp && intv && oldCount == mCm[0])) mCount = 0;
      else if (stp) mCount = oldCount + 16'd1;
      for (int i = 0; i < 2; i++) begin
        if (wrEn && wrAddr == 3'(1 + i)) mCm[i] = wrData;
        if (ld[i]) mCc[i] = oldCount;
        else if (wrEn && wrAddr == 3'(3 + i)) mCc[i] = wrData;
      end
      if (wrEn && wrAddr == 3'd0) mCtrl = wrData[7:0];
      mCmIrq = nCm; mCcIrq = nCc;
      mS3 = mS2; mS2 = mS1; mS1 = capIn;
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check(count === mCount, "R2/R3/R4 count", 32'(count), 32'(mCount));
      check(ovfFlag === mOvf, "R4/R5 ovfFlag", 32'(ovfFlag), 32'(mOvf));
      check(cmIrq === mCmIrq, "R6/R10 cmIrq", 32'(cmIrq), 32'(mCmIrq));
      check(ccIrq === mCcIrq, "R7/R8/R9 ccIrq", 32'(ccIrq), 32'(mCcIrq));
      check(ccVal0 === mCc[0], "R8/R10 ccVal0", 32'(ccVal0), 32'(mCc[0]));
      check(ccVal1 === mCc[1], "R8/R10 ccVal1", 32'(ccVal1), 32'(mCc[1]));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic idle(input int n, input bit gapped);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cntEn = gapped ? ((i % 3) != 0) : 1'b1;
    end
  endtask

  task automatic toggleCap(input int ch);
    @(negedge clk); capIn[ch] = ~capIn[ch];
    idle(6, 1'b0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 0; cntEn = 0; wrEn = 0; wrAddr = 0; wrData = 0; capIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1; cmpOn = 1;
    @(negedge clk);
    check(count == 0, "R1 count", 32'(count), 0);
    check(ovfFlag == 0, "R1 ovfFlag", 32'(ovfFlag), 0);
    check({cmIrq, ccIrq} == 0, "R1 irq", 32'({cmIrq, ccIrq}), 0);
    check({ccVal0, ccVal1} == 0, "R1 ccVal", {ccVal0, ccVal1}, 0);

    // interval mode with all four channels comparing
    wr(3'd1, 16'd5); wr(3'd2, 16'd3); wr(3'd3, 16'd2); wr(3'd4, 16'd7);
    wr(3'd0, 16'h0003);
    idle(40, 1'b0);
    idle(40, 1'b1);
    wr(3'd1, 16'd9);            // R10: new period value while running
    idle(40, 1'b1);

    // capture: ch0 both edges, ch1 rising
    wr(3'd0, 16'h007F);
    for (int r = 0; r < 3; r++) begin toggleCap(0); toggleCap(1); end
    // ch1 falling only
    wr(3'd0, 16'h00BF);
    for (int r = 0; r < 4; r++) toggleCap(1);
    // ch0 edges disabled, ch1 rising
    wr(3'd0, 16'h004F);
    for (int r = 0; r < 4; r++) begin toggleCap(0); toggleCap(1); end
    check(ccIrq[0] == 0, "R9 disabled edge", 32'(ccIrq[0]), 0);

    // R8: capture collides with a software write to the same register
    wr(3'd0, 16'h007F);
    idle(4, 1'b0);
    @(negedge clk); capIn[0] = ~capIn[0];
    @(negedge clk);
    @(negedge clk); wrEn = 1; wrAddr = 3'd3; wrData = 16'hBEEF;
    @(negedge clk); wrEn = 0;
    check(ccVal0 != 16'hBEEF, "R8 capture beats write", 32'(ccVal0), 32'(mCc[0]));
    idle(5, 1'b0);

    // R2: stopping forces zero
    wr(3'd0, 16'h0000);
    @(negedge clk);
    check(count == 0, "R2 stopped", 32'(count), 0);

    // free-running across the full range
    wr(3'd0, 16'h0001);
    cntEn = 1;
    while (!mOvf) @(negedge clk);
    check(ovfFlag == 1, "R4 flag set", 32'(ovfFlag), 1);
    check(count == 16'hFFFF, "R4 at max", 32'(count), 32'hFFFF);
    idle(3, 1'b0);
    check(count == 16'd2, "R4 wrapped", 32'(count), 2);
    wr(3'd5, 16'h0001);
    check(ovfFlag == 0, "R5 cleared", 32'(ovfFlag), 0);
    while (mCount != 16'hFFFE) @(negedge clk);
    wrEn = 1; wrAddr = 3'd5; wrData = 16'h0001;
    @(negedge clk); wrEn = 0;
    check(ovfFlag == 1, "R5 set wins", 32'(ovfFlag), 1);
    idle(10, 1'b0);
    finishRun();
  end
endmodule